// File: doc/BRIEF.md
# Multiplexed-Bus Microcontroller Support Logic

This block supplies the glue that a small 8-bit microcontroller with a shared address/data bus needs around it. It captures the low address byte from the shared bus while the address-latch-enable strobe is high. It then presents that byte on eight dedicated address outputs for the program ROM and the data RAM.

The block also performs memory-mapped decoding. It looks only at address lines A15 and A12, together with the active-low read and write strobes, and produces three selects: an active-low enable for an external SRAM, an active-high enable for an LCD, and an active-high select for the on-chip control store.

It derives the CPU clock by dividing the crystal clock by two. It also converts the active-high reset input into an active-low CPU reset. That reset output is held asserted for a fixed number of CPU clock cycles after the input is released.

All logic is synchronous to the crystal clock `clk`, except the decode and the latch bypass path, which are combinational.

Top module: `cpu_glue`

## Requirements
- R1: While `ale` is high, `addr_lo` equals `ad_bus` in the same cycle.
- R2: Once `ale` is low, `addr_lo` holds the `ad_bus` value present at the last rising `clk` edge at which `ale` was high, whatever `ad_bus` does afterwards.
- R3: `sram_ce_n` is 0 exactly when `a15` = 0 and at least one of `rd_n`, `wr_n` is 0; otherwise it is 1.
- R4: `lcd_en` is 1 exactly when `a15` = 1, `a12` = 0 and at least one of `rd_n`, `wr_n` is 0.
- R5: `store_sel` is 1 exactly when `a15` = 1, `a12` = 1 and at least one of `rd_n`, `wr_n` is 0.
- R6: At most one of the three selects is active at any time. With `rd_n` = `wr_n` = 1, none is active for any address.
- R7: `cpu_clk` is 0 while `rst_hi` is 1. Out of reset, it toggles on every rising `clk` edge, giving half the crystal frequency.
- R8: `cpu_rst_n` is 0 while `rst_hi` is 1 and stays 0 after release. It goes to 1 on the same `clk` edge as the 4096th rising edge of `cpu_clk` counted from release, and then stays 1.
- R9: Raising `rst_hi` again during or after the stretch drives `cpu_rst_n` to 0 one edge later. After the next release, the full 4096-edge count starts over.
- R10: Reset clears the held address byte to 0x00, so `addr_lo` reads 0x00 with `ale` low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_hi | input | 1 | Reset request, active high |
| ad_bus | input | 8 | Shared address/data bus from the CPU |
| ale | input | 1 | Address latch enable, high while the bus carries the low address |
| a15 | input | 1 | CPU address line 15 |
| a12 | input | 1 | CPU address line 12 |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| addr_lo | output | 8 | Latched low address byte to ROM and RAM |
| sram_ce_n | output | 1 | External SRAM enable, active low |
| lcd_en | output | 1 | LCD enable, active high |
| store_sel | output | 1 | Internal control store select, active high |
| cpu_clk | output | 1 | CPU clock, crystal divided by two |
| cpu_rst_n | output | 1 | Stretched CPU reset, active low |

## Verification
The address capture and the chip-select decode can act in the same cycle when `ale` is still high while a strobe is already low. The vector table provokes this on purpose: every row drives `ale` high together with an address pair and strobe combination. Each row is judged on both fronts at once, with `addr_lo` compared against the bus and the three selects compared against the decode map. A closing row then drops `ale` while a strobe is active, to show that the held byte survives next to a live select.

// File: rtl/glue_pkg.sv
// Shared types for the microcontroller support logic.
package glue_pkg;

    // Decode target of the current bus cycle.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SRAM  = 2'd1,
        TGT_LCD   = 2'd2,
        TGT_STORE = 2'd3
    } target_e;

endpackage

// File: rtl/glue_addr_hold.sv
// Low-address capture.
// Registers the bus on every clk edge with ale high and bypasses the bus
// straight to the output while ale is high, so the path looks transparent.
// Assumes ale is high across at least one rising clk edge per address phase.
module glue_addr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus,
    input  logic         ale,
    output logic [W-1:0] addr
);

    logic [W-1:0] held_q;

    // Capture the bus while the enable is high; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (ale)
            held_q <= bus;
    end

    // Bypass while open, held byte while closed.
    always_comb begin
        addr = ale ? bus : held_q;
    end

    // R2: a clock edge with the enable high leaves the sampled bus in the register.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (held_q == $past(bus)));

endmodule

// File: rtl/glue_decode.sv
// Memory-mapped select decode on two address lines.
// A15 low picks the SRAM; A15 high picks the LCD (A12 low) or the control
// store (A12 high). No select is active unless a read or write strobe is low.
module glue_decode
    import glue_pkg::*;
(
    input  logic a15,
    input  logic a12,
    input  logic rd_n,
    input  logic wr_n,
    output logic sram_ce_n,
    output logic lcd_en,
    output logic store_sel
);

    target_e tgt;
    logic    strobe;

    // Classify the current bus cycle.
    always_comb begin
        strobe = !rd_n || !wr_n;
        tgt    = TGT_NONE;
        if (strobe) begin
            if (!a15)
                tgt = TGT_SRAM;
            else if (a12)
                tgt = TGT_STORE;
            else
                tgt = TGT_LCD;
        end
    end

    // Drive the selects with their own polarities.
    always_comb begin
        sram_ce_n = (tgt != TGT_SRAM);
        lcd_en    = (tgt == TGT_LCD);
        store_sel = (tgt == TGT_STORE);
    end

    // R6: the three selects never overlap, and none is active without a strobe.
    always_comb begin
        p_exclusive_r6: assert ($onehot0({!sram_ce_n, lcd_en, store_sel}));
        p_idle_r6: assert (!(rd_n && wr_n) || (sram_ce_n && !lcd_en && !store_sel));
    end

endmodule

// File: rtl/glue_clkdiv.sv
// Even divider of the crystal clock.
// Produces a square CPU clock of clk/DIV and a one-cycle tick in the cycle
// before each rising edge of that clock. Held low in reset. DIV must be even.
module glue_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk,
    output logic rise_tick
);

    localparam int HALF = DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] cnt_q;
    logic          last;

    // End of a half period.
    always_comb begin
        last      = (cnt_q == DW'(HALF - 1));
        rise_tick = last && !div_clk;
    end

    // Count half periods and flip the output at the end of each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_clk <= 1'b0;
        end else if (last) begin
            cnt_q   <= '0;
            div_clk <= !div_clk;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R7: every tick is followed by a rising output edge.
    p_tick_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> $rose(div_clk));

endmodule

// File: rtl/glue_rst_stretch.sv
// Reset polarity conversion with stretch.
// Holds the active-low output for STRETCH rise ticks of the CPU clock
// after the reset input goes away; any new reset restarts the count.
module glue_rst_stretch #(
    parameter int STRETCH = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_tick,
    output logic out_rst_n
);

    localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;

    logic [CW-1:0] cnt_q;

    // Count CPU clock rises while the output is still asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            out_rst_n <= 1'b0;
        end else if (!out_rst_n && rise_tick) begin
            if (cnt_q == CW'(STRETCH - 1))
                out_rst_n <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8/R9: a reset input forces the output low one edge later.
    p_force_low_r9: assert property (@(posedge clk)
        !rst_n |=> !out_rst_n);

    // R8: once released, the output stays released.
    p_stay_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_rst_n |=> out_rst_n);

    // R8: release only happens on a CPU clock rise.
    p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rst_n) |-> $past(rise_tick));

endmodule

// File: rtl/cpu_glue.sv
// Support logic for a microcontroller with a multiplexed bus.
// Combines low-address capture, two-line select decode, CPU clock division
// and a stretched active-low CPU reset. Everything runs on the crystal clock;
// the active-high reset input acts as a synchronous reset internally.
module cpu_glue #(
    parameter int ADDR_W  = 8,
    parameter int CLK_DIV = 2,
    parameter int STRETCH = 4096
) (
    input  logic              clk,
    input  logic              rst_hi,
    input  logic [ADDR_W-1:0] ad_bus,
    input  logic              ale,
    input  logic              a15,
    input  logic              a12,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [ADDR_W-1:0] addr_lo,
    output logic              sram_ce_n,
    output logic              lcd_en,
    output logic              store_sel,
    output logic              cpu_clk,
    output logic              cpu_rst_n
);

    logic rst_n;
    logic rise_tick;

    // Internal reset in the house polarity.
    always_comb begin
        rst_n = !rst_hi;
    end

    glue_addr_hold #(.W(ADDR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (ad_bus),
        .ale   (ale),
        .addr  (addr_lo)
    );

    glue_decode u_decode (
        .a15       (a15),
        .a12       (a12),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .sram_ce_n (sram_ce_n),
        .lcd_en    (lcd_en),
        .store_sel (store_sel)
    );

    glue_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_clk   (cpu_clk),
        .rise_tick (rise_tick)
    );

    glue_rst_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tick (rise_tick),
        .out_rst_n (cpu_rst_n)
    );

endmodule

// File: tb/test_cpu_glue.sv
module test_cpu_glue;

    logic       clk = 1'b0;
    logic       rst_hi = 1'b1;
    logic [7:0] ad_bus = 8'h00;
    logic       ale = 1'b0;
    logic       a15 = 1'b0;
    logic       a12 = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr_lo;
    logic       sram_ce_n;
    logic       lcd_en;
    logic       store_sel;
    logic       cpu_clk;
    logic       cpu_rst_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cpu_glue i_cpu_glue (
        .clk       (clk),
        .rst_hi    (rst_hi),
        .ad_bus    (ad_bus),
        .ale       (ale),
        .a15       (a15),
        .a12       (a12),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr_lo   (addr_lo),
        .sram_ce_n (sram_ce_n),
        .lcd_en    (lcd_en),
        .store_sel (store_sel),
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n)
    );

    // Row: {ale, bus[7:0], a15, a12, rd_n, wr_n, exp_ce_n, exp_lcd, exp_store}
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h56, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h78, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h9A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {1'b1, 8'hBC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {1'b1, 8'hDE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic drive_step();
        @(posedge clk);
        #1;
    endtask

    // Count cpu_clk rises from release until cpu_rst_n goes high.
    task automatic measure_stretch(input string req);
        int  rises = 0;
        int  bad_toggle = 0;
        int  at_release = -1;
        logic prev = 1'b0;
        for (int i = 0; i < 9000 && at_release < 0; i++) begin
            @(negedge clk);
            if (i > 0 && cpu_clk == prev) bad_toggle++;
            if (cpu_clk && !prev) rises++;
            prev = cpu_clk;
            if (cpu_rst_n) at_release = rises;
        end
        check({"R7 cpu_clk toggles every edge (", req, ")"}, bad_toggle, 0);
        check({req, " rises of cpu_clk at reset release"}, at_release, 4096);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] last_cap = 8'h00;

        // Reset state: R7, R8, R10, R6.
        repeat (4) drive_step();
        @(negedge clk);
        check("R8 cpu_rst_n low in reset", cpu_rst_n, 0);
        check("R7 cpu_clk low in reset", cpu_clk, 0);
        check("R10 addr_lo cleared", addr_lo, 8'h00);
        check("R6 no select idle", {!sram_ce_n, lcd_en, store_sel}, 0);

        // Release and measure the stretch: R8.
        drive_step();
        rst_hi = 1'b0;
        measure_stretch("R8");
        drive_step();
        check("R8 cpu_rst_n stays high", cpu_rst_n, 1);

        // Vector table: capture and decode in the same cycle (R1, R3-R6, R2).
        for (int v = 0; v < NV; v++) begin
            drive_step();
            {ale, ad_bus, a15, a12, rd_n, wr_n} = VEC[v][15:3];
            @(negedge clk);
            if (VEC[v][15]) begin
                check($sformatf("R1 addr follows bus row %0d", v), addr_lo, VEC[v][14:7]);
                last_cap = VEC[v][14:7];
            end else begin
                check($sformatf("R2 addr holds row %0d", v), addr_lo, last_cap);
            end
            check($sformatf("R3 sram_ce_n row %0d", v), sram_ce_n, VEC[v][2]);
            check($sformatf("R4 lcd_en row %0d", v), lcd_en, VEC[v][1]);
            check($sformatf("R5 store_sel row %0d", v), store_sel, VEC[v][0]);
            check($sformatf("R6 exclusive row %0d", v),
                  $countones({!sram_ce_n, lcd_en, store_sel}) <= 1, 1);
        end

        // R2: bus changes after ale drops are not seen.
        drive_step();
        rd_n = 1'b1; wr_n = 1'b1;
        ale = 1'b1; ad_bus = 8'hA5;
        drive_step();
        ale = 1'b0; ad_bus = 8'h3C;
        @(negedge clk);
        check("R2 held after ale falls", addr_lo, 8'hA5);
        drive_step();
        ad_bus = 8'hC3;
        @(negedge clk);
        check("R2 held across bus change", addr_lo, 8'hA5);

        // R9 and R10: reset after stretch.
        drive_step();
        rst_hi = 1'b1;
        drive_step();
        @(negedge clk);
        check("R9 cpu_rst_n low one edge after reset", cpu_rst_n, 0);
        check("R10 addr_lo cleared by reset", addr_lo, 8'h00);
        check("R7 cpu_clk low in reset again", cpu_clk, 0);

        // R9: interrupt a stretch midway, then measure a full fresh count.
        drive_step();
        rst_hi = 1'b0;
        repeat (2000) drive_step();
        @(negedge clk);
        check("R9 still low mid stretch", cpu_rst_n, 0);
        drive_step();
        rst_hi = 1'b1;
        repeat (2) drive_step();
        rst_hi = 1'b0;
        measure_stretch("R9");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule